// File: doc/BRIEF.md
# Control Endpoint Status Register

This block holds the six status flags of a USB device's control endpoint: a stall flag, a NAK flag and a data-toggle flag for each of the OUT and IN directions. Software reads the flags and flips them through a plain register bus. Each written 1 inverts the matching flag, so software can set or clear a flag only after reading its current value. The USB transaction engine sends single-cycle event pulses that update the same flags in hardware. These events are a SETUP token, an OUT data packet arriving, and the host acknowledging an IN packet.

The block also tells the transaction engine how to answer. For an OUT data packet it gives STALL, NAK or ACK, and it says whether the payload is kept. For an IN token it gives STALL, NAK or "send data", together with the data PID to use. Packet serialization, CRC, token decoding, buffers and the other endpoints are handled elsewhere.

Top module: `ep0_csr`

## Requirements
- R1: After reset the register reads 0x0000_0002 at byte address 0x014. Bits 31..6 always read 0. Any other address reads 0.
- R2: Bit positions are fixed: bit 5 = OUT stall, bit 4 = OUT NAK, bit 3 = OUT toggle, bit 2 = IN stall, bit 1 = IN NAK, bit 0 = IN toggle. A write to 0x014 inverts every flag whose write-data bit is 1 and leaves flags with a 0 unchanged. Writes to any other address change nothing.
- R3: The OUT handshake code is 2 (STALL) when OUT stall is 1. Otherwise it is 1 (NAK) when OUT NAK is 1. Otherwise it is 0 (ACK).
- R4: The IN handshake code uses the same encoding, from IN stall and IN NAK, where 0 means send data. The IN data PID output equals the IN toggle (0 = DATA0, 1 = DATA1).
- R5: A SETUP pulse clears both stall flags and sets the OUT toggle to 1. The other flags are unchanged.
- R6: An OUT packet pulse behaves as follows when the OUT handshake is ACK and the packet PID bit equals the OUT toggle. The keep output is 1 in that cycle. On the next edge the OUT toggle inverts and OUT NAK becomes 1.
- R7: Some OUT packet pulses leave every flag unchanged and hold keep at 0. This applies when the PID does not match but the handshake is ACK, and when the handshake is STALL or NAK.
- R8: An IN-acknowledge pulse inverts the IN toggle.
- R9: A register write may land in the same cycle as a hardware event. The hardware update is applied first, and the write's inversions are applied to that result.
- R10: A SETUP pulse and an OUT packet pulse may arrive in the same cycle. The SETUP takes effect, the OUT packet is ignored, and keep stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data (1 bits invert flags) |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| setup_evt | input | 1 | SETUP token received for this endpoint |
| out_pkt_evt | input | 1 | Valid OUT data packet received |
| out_pkt_pid1 | input | 1 | PID of that packet is DATA1 |
| out_hs | output | 2 | OUT handshake code (0 ACK, 1 NAK, 2 STALL) |
| out_keep | output | 1 | OUT payload accepted this cycle |
| in_ack_evt | input | 1 | Host acknowledged an IN packet |
| in_hs | output | 2 | IN response code (0 data, 1 NAK, 2 STALL) |
| in_pid1 | output | 1 | IN packet must use DATA1 |

## Verification
The assertions assume that event pulses are one cycle wide. They also assume that the engine raises an IN acknowledge only when the IN handshake was "send data". The flip checks are written only for cycles with no register write, because a same-cycle write may invert the flag back. The random stimulus keeps the pulses single-cycle. It issues writes and events in the same cycle on purpose, so the R9 and R10 ordering is exercised against the bench's own model. The checks whose premises exclude writes still see many write-free cycles.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    localparam int unsigned CSR_W = 6;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    typedef struct packed {
        logic out_stall;
        logic out_nak;
        logic out_tgl;
        logic in_stall;
        logic in_nak;
        logic in_tgl;
    } csr_t;

    localparam csr_t CSR_RESET = '{out_stall: 1'b0, out_nak: 1'b0, out_tgl: 1'b0,
                                   in_stall: 1'b0, in_nak: 1'b1, in_tgl: 1'b0};

endpackage

// File: rtl/ep0_hs_sel.sv
module ep0_hs_sel
    import ep0_csr_pkg::*;
(
    input  logic stall,
    input  logic nak,
    output hs_e  hs
);
    always_comb begin
        if (stall) begin
            hs = HS_STALL;
        end else if (nak) begin
            hs = HS_NAK;
        end else begin
            hs = HS_ACK;
        end
    end
endmodule

// File: rtl/ep0_hw_update.sv
module ep0_hw_update
    import ep0_csr_pkg::*;
(
    input  csr_t cur,
    input  logic setup,
    input  logic out_ok,
    input  logic in_ack,
    output csr_t nxt
);
    always_comb begin
        nxt = cur;
        if (setup) begin
            nxt.out_stall = 1'b0;
            nxt.in_stall  = 1'b0;
            nxt.out_tgl   = 1'b1;
        end else if (out_ok) begin
            nxt.out_tgl = ~cur.out_tgl;
            nxt.out_nak = 1'b1;
        end
        if (in_ack) begin
            nxt.in_tgl = ~cur.in_tgl;
        end
    end
endmodule

// File: rtl/ep0_sw_toggle.sv
module ep0_sw_toggle
    import ep0_csr_pkg::*;
(
    input  csr_t             base,
    input  logic             hit,
    input  logic [CSR_W-1:0] flip,
    output csr_t             res
);
    logic [CSR_W-1:0] base_v;
    logic [CSR_W-1:0] res_v;

    assign base_v = base;

    for (genvar b = 0; b < CSR_W; b++) begin : g_bit
        assign res_v[b] = base_v[b] ^ (hit & flip[b]);
    end

    assign res = csr_t'(res_v);
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
    import ep0_csr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter logic [11:0] CSR_ADDR = 12'h014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              setup_evt,
    input  logic              out_pkt_evt,
    input  logic              out_pkt_pid1,
    output logic [1:0]        out_hs,
    output logic              out_keep,
    input  logic              in_ack_evt,
    output logic [1:0]        in_hs,
    output logic              in_pid1
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CSR_ADDR);
    localparam int unsigned       PAD_W    = DATA_W - CSR_W;
    localparam int unsigned       N_DIR    = 2;

    typedef struct packed {
        csr_t flags;
    } state_t;

    state_t st_d, st_q;

    logic       addr_hit;
    logic       wr_hit;
    logic       out_ok;
    csr_t       after_hw;
    csr_t       after_sw;
    logic [CSR_W-1:0] csr_bits;
    logic       unused_wdata;

    logic [N_DIR-1:0] dir_stall;
    logic [N_DIR-1:0] dir_nak;
    hs_e              dir_hs [N_DIR];

    assign csr_bits = st_q.flags;
    assign addr_hit = (bus_addr == SEL_ADDR);
    assign wr_hit   = bus_we & addr_hit;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CSR_W];

    assign dir_stall[0] = st_q.flags.out_stall;
    assign dir_nak[0]   = st_q.flags.out_nak;
    assign dir_stall[1] = st_q.flags.in_stall;
    assign dir_nak[1]   = st_q.flags.in_nak;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ep0_hs_sel u_hs (
            .stall (dir_stall[d]),
            .nak   (dir_nak[d]),
            .hs    (dir_hs[d])
        );
    end

    assign out_ok = out_pkt_evt & ~setup_evt & (dir_hs[0] == HS_ACK)
                  & (out_pkt_pid1 == st_q.flags.out_tgl);

    ep0_hw_update u_hw (
        .cur    (st_q.flags),
        .setup  (setup_evt),
        .out_ok (out_ok),
        .in_ack (in_ack_evt),
        .nxt    (after_hw)
    );

    ep0_sw_toggle u_sw (
        .base (after_hw),
        .hit  (wr_hit),
        .flip (bus_wdata[CSR_W-1:0]),
        .res  (after_sw)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = after_sw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= CSR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = addr_hit ? {{PAD_W{1'b0}}, csr_bits} : '0;
    assign out_hs    = dir_hs[0];
    assign in_hs     = dir_hs[1];
    assign out_keep  = out_ok;
    assign in_pid1   = st_q.flags.in_tgl;
endmodule

// File: rtl/ep0_csr_chk.sv
module ep0_csr_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        csr,
    input logic [DATA_W-1:0] rdata,
    input logic              we,
    input logic              setup,
    input logic              out_pkt,
    input logic              in_ack,
    input logic [1:0]        out_hs,
    input logic [1:0]        in_hs,
    input logic              keep
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:6] == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !setup && !out_pkt && !in_ack) |=> $stable(csr));

    p_out_stall_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr[5] |-> out_hs == 2'd2);

    p_in_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr[2] && csr[1]) |-> in_hs == 2'd1);

    p_setup_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (setup && !we) |=> (!csr[5] && !csr[2] && csr[3]));

    p_keep_sets_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && !we) |=> csr[4]);

    p_keep_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        keep |-> (out_hs == 2'd0 && out_pkt));

    p_in_ack_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && !we) |=> csr[0] != $past(csr[0]));

    p_setup_blocks_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        setup |-> !keep);
endmodule

bind ep0_csr ep0_csr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csr     (csr_bits),
    .rdata   (bus_rdata),
    .we      (bus_we),
    .setup   (setup_evt),
    .out_pkt (out_pkt_evt),
    .in_ack  (in_ack_evt),
    .out_hs  (out_hs),
    .in_hs   (in_hs),
    .keep    (out_keep)
);

// File: tb/ep0_csr_tb.sv
module ep0_csr_tb;
    localparam logic [11:0] OFF = 12'h014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = OFF;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        setup_evt = 1'b0, out_pkt_evt = 1'b0, out_pkt_pid1 = 1'b0, in_ack_evt = 1'b0;
    logic [1:0]  out_hs, in_hs;
    logic        out_keep, in_pid1;

    int n_chk = 0;
    int n_err = 0;
    logic [5:0] model = 6'b000010;

    always #10 clk = ~clk;

    ep0_csr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .setup_evt(setup_evt),
        .out_pkt_evt(out_pkt_evt), .out_pkt_pid1(out_pkt_pid1), .out_hs(out_hs),
        .out_keep(out_keep), .in_ack_evt(in_ack_evt), .in_hs(in_hs), .in_pid1(in_pid1)
    );

    function automatic logic [1:0] hs_of(logic stall, logic nak);
        return stall ? 2'd2 : (nak ? 2'd1 : 2'd0);
    endfunction

    function automatic logic keep_of(logic [5:0] s, logic su, logic op, logic pid);
        return op && !su && !s[5] && !s[4] && (pid == s[3]);
    endfunction

    function automatic logic [5:0] next_of(logic [5:0] s, logic hit, logic [5:0] wd,
                                           logic su, logic op, logic pid, logic ia);
        logic [5:0] n = s;
        if (su) begin
            n[5] = 1'b0; n[2] = 1'b0; n[3] = 1'b1;
        end else if (keep_of(s, su, op, pid)) begin
            n[3] = ~s[3]; n[4] = 1'b1;
        end
        if (ia) n[0] = ~n[0];
        if (hit) n = n ^ wd;
        return n;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Called at a negedge: check state, apply stimulus, clock once.
    task automatic step(logic we, logic [11:0] a, logic [31:0] wd, logic su,
                        logic op, logic pid, logic ia, string req);
        bus_we = 0; bus_addr = OFF; setup_evt = 0; out_pkt_evt = 0; in_ack_evt = 0;
        #1;
        chk({req, " state R2"}, bus_rdata, {26'b0, model});
        chk("R3 out_hs", {30'b0, out_hs}, {30'b0, hs_of(model[5], model[4])});
        chk("R4 in_hs", {30'b0, in_hs}, {30'b0, hs_of(model[2], model[1])});
        chk("R4 in_pid1", {31'b0, in_pid1}, {31'b0, model[0]});
        bus_we = we; bus_addr = a; bus_wdata = wd; setup_evt = su;
        out_pkt_evt = op; out_pkt_pid1 = pid; in_ack_evt = ia;
        #1;
        chk({req, " keep R6 R7 R10"}, {31'b0, out_keep}, {31'b0, keep_of(model, su, op, pid)});
        @(posedge clk);
        model = next_of(model, we && (a == OFF), wd[5:0], su, op, pid, ia);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset value", bus_rdata, 32'h0000_0002);
        bus_addr = 12'h018; #1;
        chk("R1 other address", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: invert individual flags, then zero write, then off-address write
        for (int b = 0; b < 6; b++) step(1, OFF, 32'h1 << b, 0, 0, 0, 0, "R2 flip");
        step(1, OFF, 32'h0, 0, 0, 0, 0, "R2 zero write");
        step(1, 12'h010, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 other address");
        chk("R2 all flipped", {26'b0, model}, 32'h3D);
        step(1, OFF, 32'hFFFF_FFC0 | {26'b0, model}, 0, 0, 0, 0, "R2 clear all");
        // R5: stalls on, then SETUP
        step(1, OFF, 32'h24, 0, 0, 0, 0, "R3 stall on");
        step(0, OFF, 0, 1, 0, 0, 0, "R5 setup");
        chk("R5 after setup", {26'b0, model}, 32'h08);
        // R6: several OUT transfers, software clearing NAK between
        for (int t = 0; t < 4; t++) begin
            step(0, OFF, 0, 0, 1, model[3], 0, "R6 out accept");
            step(1, OFF, 32'h10, 0, 0, 0, 0, "R6 nak clear");
        end
        // R7: mismatched PID, then packet while NAK/STALL set
        step(0, OFF, 0, 0, 1, ~model[3], 0, "R7 mismatch");
        step(1, OFF, 32'h10, 0, 0, 0, 0, "R7 nak on");
        step(0, OFF, 0, 0, 1, model[3], 0, "R7 nak blocks");
        step(1, OFF, 32'h30, 0, 0, 0, 0, "R7 stall on");
        step(0, OFF, 0, 0, 1, model[3], 0, "R7 stall blocks");
        // R8 and R9: IN ack alone, then with a write to the same bit
        step(0, OFF, 0, 0, 0, 0, 1, "R8 in ack");
        step(1, OFF, 32'h01, 0, 0, 0, 1, "R9 collide in tgl");
        step(1, OFF, 32'h28, 1, 0, 0, 0, "R9 collide setup");
        // R10: SETUP with OUT packet
        step(1, OFF, 32'h10, 0, 0, 0, 0, "R10 prep");
        step(0, OFF, 0, 1, 1, model[3], 0, "R10 setup wins");
        step(0, OFF, 0, 0, 0, 0, 0, "R10 settle");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic we = (r[2:0] == 3'd0);
            logic [11:0] a = r[3] ? 12'h01C : OFF;
            logic [31:0] wd = $urandom;
            logic su = (r[7:4] == 4'd0);
            logic op = r[8] & r[9];
            logic pid = r[10] ? model[3] : r[11];
            logic ia = r[12] & r[13];
            step(we, a, wd, su, op, pid, ia, "R9 random");
        end
        summary();
    end
endmodule